// File: doc/BRIEF.md
# Display Interrupt Status and Enable Register

This block holds the interrupt state of a display controller in one 32-bit word. Three display events arrive as single-cycle pulses from the timing logic: frame start, vertical sync start and vertical sync end. Each pulse sets its own status flag in the low byte. Three enable bits in the second byte choose which flags may raise the single level-sensitive interrupt line.

Software acknowledges events by writing the word with zeros in the flag positions it wants cleared. A one in a flag position leaves that flag as it is. The same write loads the enable bits. A handler can therefore acknowledge every pending event and turn off one enable in a single access. A second read-only word reports which panel channel, main or sub, produced the most recent frame-start event.

Top module: `disp_irq_reg`

## Requirements
- R1: After reset the interrupt word, the status word and `irq_o` are all zero.
- R2: An event pulse sets its flag in the interrupt word on the next clock edge, whether or not the flag is enabled. The flag positions are: vertical sync end at bit 0, vertical sync start at bit 1, frame start at bit 2.
- R3: A write with a 0 in flag bit i clears that flag. A write with a 1 in flag bit i leaves the flag unchanged.
- R4: If an event pulse arrives in the same cycle as a write that clears its flag, the flag ends up set.
- R5: Every write loads the enables from data bits 10:8: vertical sync end at bit 8, vertical sync start at bit 9, frame start at bit 10. Cycles without a write leave the enables unchanged.
- R6: `irq_o` is high exactly one cycle after a cycle in which some flag and its matching enable are both set. It is low otherwise.
- R7: A single write of 0x600 acknowledges every pending flag and disables only the vertical sync end enable. The frame start and vertical sync start enables stay on.
- R8: Bit 10 of the status word takes the value of `ev_from_sub_i` on every frame-start pulse (1 = sub panel, 0 = main panel). Vertical sync events do not change it.
- R9: Bits 7:3 and 31:11 of the interrupt word and every status-word bit except bit 10 read as zero, including after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the interrupt word |
| wr_data_i | input | 32 | Write data: flag acknowledge bits and enable bits |
| ev_frame_start_i | input | 1 | Frame start event pulse |
| ev_vsync_start_i | input | 1 | Vertical sync start event pulse |
| ev_vsync_end_i | input | 1 | Vertical sync end event pulse |
| ev_from_sub_i | input | 1 | Panel of the frame event: 1 = sub, 0 = main |
| int_word_o | output | 32 | Interrupt word readback (flags and enables) |
| stat_word_o | output | 32 | Status word readback (panel source at bit 10) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check every cycle for these rules: each event sets its flag, zero-writes clear flags and one-writes keep them, an event wins over a simultaneous clear, the enables load only on writes, the interrupt line follows the pending set with one cycle of latency, the panel bit changes only on frame start, and the reserved bits stay at zero. The bench scenarios cover what the assertions cannot: the exact word values reached after a sequence of events and writes. These include the acknowledge-and-disable handler write, the line staying low while a flag is pending but not enabled, and the fact that the interrupt line does not drop until the cycle after an acknowledge.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

  // Next value of one event flag: an event always sets it, and a write with
  // a zero in the flag position clears it.
  function automatic logic flag_next(input logic cur, input logic ev,
                                     input logic wr, input logic wbit);
    logic clr;
    clr = wr & ~wbit;
    return ev | (cur & ~clr);
  endfunction

  // Any flag that is both pending and enabled.
  function automatic logic any_armed(input logic [7:0] flags,
                                     input logic [7:0] enables);
    return |(flags & enables);
  endfunction

endpackage

// File: rtl/disp_irq_flag.sv
module disp_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  import disp_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_next(flag_o, ev_i, wr_en_i, wr_bit_i);
  end
endmodule

// File: rtl/disp_irq_enables.sv
module disp_irq_enables #(
  parameter int N_EV = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [N_EV-1:0] wr_en_bits_i,
  output logic [N_EV-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       en_o <= '0;
    else if (wr_en_i) en_o <= wr_en_bits_i;
  end
endmodule

// File: rtl/disp_irq_line.sv
module disp_irq_line #(
  parameter int N_EV = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] flags_i,
  input  logic [N_EV-1:0] en_i,
  output logic            armed_o,
  output logic            irq_o
);
  import disp_irq_pkg::*;

  logic [7:0] flags_w, en_w;

  always_comb begin
    flags_w = '0;
    en_w    = '0;
    flags_w[N_EV-1:0] = flags_i;
    en_w[N_EV-1:0]    = en_i;
    armed_o = any_armed(flags_w, en_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= armed_o;
  end
endmodule

// File: rtl/disp_irq_reg.sv
module disp_irq_reg #(
  parameter int DATA_W  = 32,
  parameter int N_EV    = 3,
  parameter int EN_LSB  = 8,
  parameter int SRC_POS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ev_frame_start_i,
  input  logic              ev_vsync_start_i,
  input  logic              ev_vsync_end_i,
  input  logic              ev_from_sub_i,
  output logic [DATA_W-1:0] int_word_o,
  output logic [DATA_W-1:0] stat_word_o,
  output logic              irq_o
);
  localparam int FS_IDX = N_EV - 1;

  // Named internal events, visible to the checker.
  logic [N_EV-1:0] ev_vec;
  logic [N_EV-1:0] flag_vec;
  logic [N_EV-1:0] en_vec;
  logic            armed;
  logic            src_sub_q;
  logic            unused_wr_bits;

  // Flag order: bit 0 vsync end, bit 1 vsync start, top bit frame start.
  always_comb begin
    ev_vec         = '0;
    ev_vec[0]      = ev_vsync_end_i;
    ev_vec[1]      = ev_vsync_start_i;
    ev_vec[FS_IDX] = ev_frame_start_i;
  end

  generate
    for (genvar i = 0; i < N_EV; i++) begin : g_flag
      disp_irq_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev_vec[i]),
        .wr_en_i  (wr_en_i),
        .wr_bit_i (wr_data_i[i]),
        .flag_o   (flag_vec[i])
      );
    end
  endgenerate

  disp_irq_enables #(.N_EV(N_EV)) u_en (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_en_bits_i (wr_data_i[EN_LSB +: N_EV]),
    .en_o         (en_vec)
  );

  disp_irq_line #(.N_EV(N_EV)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flag_vec),
    .en_i    (en_vec),
    .armed_o (armed),
    .irq_o   (irq_o)
  );

  // Panel that produced the latest frame-start event.
  always_ff @(posedge clk) begin
    if (!rst_n)                src_sub_q <= 1'b0;
    else if (ev_frame_start_i) src_sub_q <= ev_from_sub_i;
  end

  always_comb begin
    int_word_o                    = '0;
    int_word_o[N_EV-1:0]          = flag_vec;
    int_word_o[EN_LSB +: N_EV]    = en_vec;
    stat_word_o                   = '0;
    stat_word_o[SRC_POS]          = src_sub_q;
  end

  assign unused_wr_bits = ^{wr_data_i, armed};
endmodule

// File: rtl/disp_irq_chk.sv
module disp_irq_chk #(
  parameter int DATA_W  = 32,
  parameter int N_EV    = 3,
  parameter int EN_LSB  = 8,
  parameter int SRC_POS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [N_EV-1:0]   ev_vec,
  input logic              ev_from_sub_i,
  input logic [DATA_W-1:0] int_word_o,
  input logic [DATA_W-1:0] stat_word_o,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] INT_MASK =
    ((DATA_W'(1) << N_EV) - 1) | (((DATA_W'(1) << N_EV) - 1) << EN_LSB);
  localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(1) << SRC_POS;
  localparam int FS_IDX = N_EV - 1;

  generate
    for (genvar i = 0; i < N_EV; i++) begin : g_bit
      AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vec[i] |=> int_word_o[i]); // R2
      AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[i] && !ev_vec[i]) |=> !int_word_o[i]); // R3
      AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[i] && !ev_vec[i]) |=> $stable(int_word_o[i])); // R3
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[i] && ev_vec[i]) |=> int_word_o[i]); // R4
    end
  endgenerate

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> int_word_o[EN_LSB +: N_EV] == $past(wr_data_i[EN_LSB +: N_EV])); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(int_word_o[EN_LSB +: N_EV])); // R5
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(int_word_o[N_EV-1:0] & int_word_o[EN_LSB +: N_EV]))); // R6
  AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec[FS_IDX] |=> stat_word_o[SRC_POS] == $past(ev_from_sub_i)); // R8
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_vec[FS_IDX] |=> $stable(stat_word_o[SRC_POS])); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_word_o & ~INT_MASK) == '0) && ((stat_word_o & ~STAT_MASK) == '0)); // R9
endmodule

bind disp_irq_reg disp_irq_chk #(
  .DATA_W(DATA_W), .N_EV(N_EV), .EN_LSB(EN_LSB), .SRC_POS(SRC_POS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .ev_vec        (ev_vec),
  .ev_from_sub_i (ev_from_sub_i),
  .int_word_o    (int_word_o),
  .stat_word_o   (stat_word_o),
  .irq_o         (irq_o)
);

// File: tb/disp_irq_reg_tb.sv
`timescale 1ns/1ps
module disp_irq_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ev_fs = 1'b0, ev_vss = 1'b0, ev_vse = 1'b0, ev_sub = 1'b0;
  logic [31:0] int_word, stat_word;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  disp_irq_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ev_frame_start_i(ev_fs), .ev_vsync_start_i(ev_vss),
    .ev_vsync_end_i(ev_vse), .ev_from_sub_i(ev_sub),
    .int_word_o(int_word), .stat_word_o(stat_word), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; evm bit2 = frame start, bit1 = vsync start, bit0 = vsync end.
  task automatic step(input logic w, input logic [31:0] d, input logic [2:0] evm, input logic sub);
    @(negedge clk);
    wr_en = w; wr_data = d;
    ev_fs = evm[2]; ev_vss = evm[1]; ev_vse = evm[0]; ev_sub = sub;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev_fs = 1'b0; ev_vss = 1'b0; ev_vse = 1'b0; ev_sub = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 int word", int_word, 32'h0);
    check("R1 status word", stat_word, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_capture();
    step(1'b0, '0, 3'b001, 1'b0);
    check("R2 vsync end sets bit0", int_word, 32'h1);
    idle();
    check("R6 disabled flag no irq", {31'b0, irq}, 32'h0);
    step(1'b0, '0, 3'b100, 1'b1);
    check("R2 frame start sets bit2", int_word, 32'h5);
    check("R8 sub panel source", stat_word, 32'h400);
    step(1'b0, '0, 3'b010, 1'b0);
    check("R2 vsync start sets bit1", int_word, 32'h7);
    check("R8 vsync leaves source", stat_word, 32'h400);
  endtask

  task automatic t_clear();
    step(1'b1, 32'h6, 3'b000, 1'b0);
    check("R3 zero clears, one keeps", int_word, 32'h6);
    step(1'b1, 32'h0, 3'b000, 1'b0);
    check("R3 zero clears all", int_word, 32'h0);
  endtask

  task automatic t_irq();
    step(1'b1, 32'h700, 3'b000, 1'b0);
    check("R5 enables loaded", int_word, 32'h700);
    idle();
    check("R6 no pending no irq", {31'b0, irq}, 32'h0);
    step(1'b0, '0, 3'b010, 1'b0);
    check("R2 enabled flag set", int_word, 32'h702);
    check("R6 irq one cycle later, not yet", {31'b0, irq}, 32'h0);
    idle();
    check("R6 irq raised", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_ack_disable();
    step(1'b1, 32'h600, 3'b000, 1'b0);
    check("R7 ack and vsync end disable", int_word, 32'h600);
    check("R6 irq lags ack by a cycle", {31'b0, irq}, 32'h1);
    idle();
    check("R6 irq drops after ack", {31'b0, irq}, 32'h0);
    step(1'b0, '0, 3'b001, 1'b0);
    check("R7 vsync end still flagged", int_word, 32'h601);
    idle();
    check("R7 disabled vsync end no irq", {31'b0, irq}, 32'h0);
    step(1'b0, '0, 3'b100, 1'b0);
    check("R8 main panel source", stat_word, 32'h0);
    idle();
    check("R7 frame start enable kept", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_race();
    step(1'b1, 32'h600, 3'b100, 1'b1);
    check("R4 event wins over clear", int_word, 32'h604);
    check("R8 source on racing event", stat_word, 32'h400);
  endtask

  task automatic t_reserved();
    step(1'b1, 32'h0, 3'b000, 1'b0);
    step(1'b1, 32'hFFFF_FFFF, 3'b000, 1'b0);
    check("R9 reserved bits zero", int_word, 32'h700);
    check("R9 status word only bit10", stat_word, 32'h400);
    step(1'b1, 32'h0, 3'b000, 1'b0);
    check("R5 enables cleared", int_word, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_clear();
    t_irq();
    t_ack_disable();
    t_race();
    t_reserved();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #20000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule